// File: doc/BRIEF.md
# Card Window Decoder with Byte Steering

This block implements one address window of a bridge that sits between a PC-card host bus and a disk-drive bus. On every host access it decides whether the window is selected. It can decode either memory-space or I/O-space cycles. When address comparison is turned on, it also checks the host address against a programmable base and mask. On a hit it drives one of two active-low drive-side chip selects.

Data passes between the 16-bit host bus and the 16-bit drive bus. The two byte lanes either go straight through or swap places. Read data can be kept off the host bus entirely, so that two cards can answer at the same read address. Each accepted access can be stretched by holding the active-low host wait line for up to three master-clock periods.

All of these options come from one control byte. The window base and mask are loaded through the same simple register port.

Top module: `cwin_decoder`

## Requirements
- R1: After reset the control byte reads 8'h01 at offset 8'h18, and the base and mask registers read 0. The window is then disabled: driveCsN = 2'b11, hostWaitN = 1 and hostDataOe = 0.
- R2: A register write (regWrEn high at a clock edge) at offset 8'h18 stores the control byte. Offsets 8'h20/8'h21 hold the base address low/high byte, and offsets 8'h22/8'h23 hold the mask low/high byte. Every register reads back on regRdData combinationally. Any other offset reads 0.
- R3: Control bit 0 set disables the window. There is then no chip select, no wait and no host data drive, whatever the host does.
- R4: Control bit 1 picks the decode space. With 1, only accesses with hostMemSpace = 1 can hit; with 0, only accesses with hostMemSpace = 0 can hit.
- R5: Control bit 4 set enables address comparison. An access then hits only when (hostAddr & mask) == (base & mask). With bit 4 clear, every access with hostCardSel high and the right space hits.
- R6: On a hit, control bit 5 picks the drive chip select: 0 pulls driveCsN[0] low, 1 pulls driveCsN[1] low. The other line stays high. Both lines are high when there is no hit.
- R7: Control bit 2 set makes hostDataOut = {driveDataIn[7:0], driveDataIn[15:8]}. With bit 2 clear, hostDataOut = driveDataIn.
- R8: Control bit 2 set makes driveDataOut = {hostDataIn[7:0], hostDataIn[15:8]}. With bit 2 clear, driveDataOut = hostDataIn. driveDataOe is high exactly when a write strobe meets a hit.
- R9: hostDataOe is high exactly when a read strobe meets a hit while control bit 3 (read protect) is clear. With bit 3 set, it stays low.
- R10: Control bits 7:6 give a wait count N. An accepted access (a hit with a read or write strobe) holds hostWaitN low for exactly N clock cycles, starting at the cycle the access begins. With N = 0, hostWaitN stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 8 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regSel |
| hostCardSel | input | 1 | Host card select, active high |
| hostMemSpace | input | 1 | 1 for a memory-space access, 0 for I/O space |
| hostRdStb | input | 1 | Host read strobe, active high |
| hostWrStb | input | 1 | Host write strobe, active high |
| hostAddr | input | ADDR_W | Host address |
| hostDataIn | input | 16 | Host write data |
| hostDataOut | output | 16 | Steered read data toward the host |
| hostDataOe | output | 1 | Host data bus drive enable |
| hostWaitN | output | 1 | Host wait, active low |
| driveDataIn | input | 16 | Drive read data |
| driveDataOut | output | 16 | Steered write data toward the drive |
| driveDataOe | output | 1 | Drive data bus drive enable |
| driveCsN | output | 2 | Drive chip selects, active low |

## Verification
The assertions assume that read and write strobes are never high together. They also assume that the control byte is not rewritten while an access is in progress: the wait counter checks rely on a stable wait count during an access. The stimulus follows both rules. It writes configuration only while every host strobe is low, drives one strobe at a time, and drops the strobes between accesses so that each access starts fresh.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
  localparam int LANE_W = 8;
  localparam int DATA_W = 2 * LANE_W;
  localparam int WAIT_W = 2;
  localparam logic [7:0] CTRL_OFS = 8'h18;
  localparam logic [7:0] BASE_OFS = 8'h20;
  localparam logic [7:0] CTRL_RESET = 8'h01;

  // field order matches the control byte, bit 7 down to bit 0
  typedef struct packed {
    logic [WAIT_W-1:0] waitStates;
    logic              csSel;
    logic              cmpEn;
    logic              rdProt;
    logic              swapEn;
    logic              memMode;
    logic              winOff;
  } cfg_t;

  typedef struct packed {
    logic hit;
    logic rdDrive;
    logic wrDrive;
  } strobe_t;
endpackage

// File: rtl/cwin_datapath.sv
module cwin_datapath
  import cwin_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regSel,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  input  logic [DATA_W-1:0] driveDataIn,
  output logic [DATA_W-1:0] driveDataOut,
  output logic              driveDataOe,
  input  strobe_t           stb,
  output cfg_t              cfg,
  output logic              addrMatch
);
  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int PAD_W = ADDR_BYTES * 8;
  localparam logic [7:0] MASK_OFS = BASE_OFS + 8'(ADDR_BYTES);

  logic [7:0]       ctrlReg;
  logic [PAD_W-1:0] baseReg;
  logic [PAD_W-1:0] maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      baseReg <= '0;
      maskReg <= '0;
    end else if (regWrEn) begin
      if (regSel == CTRL_OFS) ctrlReg <= regWrData;
      for (int b = 0; b < ADDR_BYTES; b++) begin
        if (regSel == BASE_OFS + 8'(b)) baseReg[b*8 +: 8] <= regWrData;
        if (regSel == MASK_OFS + 8'(b)) maskReg[b*8 +: 8] <= regWrData;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regSel == CTRL_OFS) regRdData = ctrlReg;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (regSel == BASE_OFS + 8'(b)) regRdData = baseReg[b*8 +: 8];
      if (regSel == MASK_OFS + 8'(b)) regRdData = maskReg[b*8 +: 8];
    end
  end

  assign cfg = cfg_t'(ctrlReg);
  assign addrMatch = ((hostAddr ^ baseReg[ADDR_W-1:0]) & maskReg[ADDR_W-1:0]) == '0;

  // byte lane steering, same swap rule in both directions
  always_comb begin
    if (cfg.swapEn) begin
      hostDataOut  = {driveDataIn[LANE_W-1:0], driveDataIn[DATA_W-1:LANE_W]};
      driveDataOut = {hostDataIn[LANE_W-1:0], hostDataIn[DATA_W-1:LANE_W]};
    end else begin
      hostDataOut  = driveDataIn;
      driveDataOut = hostDataIn;
    end
  end

  assign hostDataOe  = stb.rdDrive;
  assign driveDataOe = stb.wrDrive;

  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == CTRL_OFS) |=> (regRdData == $past(regWrData) || regSel != CTRL_OFS)); // R2
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(hostDataOe && driveDataOe)); // R8
endmodule

// File: rtl/cwin_control.sv
module cwin_control
  import cwin_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  logic    addrMatch,
  input  logic    hostCardSel,
  input  logic    hostMemSpace,
  input  logic    hostRdStb,
  input  logic    hostWrStb,
  output strobe_t stb,
  output logic    hostWaitN,
  output logic [1:0] driveCsN
);
  logic              decodeHit;
  logic              accAct;
  logic              accPrev;
  logic              accStart;
  logic [WAIT_W-1:0] waitCnt;
  logic              waitOn;

  assign decodeHit = !cfg.winOff && hostCardSel && (hostMemSpace == cfg.memMode)
                     && (!cfg.cmpEn || addrMatch);
  assign accAct   = decodeHit && (hostRdStb || hostWrStb);
  assign accStart = accAct && !accPrev;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_cs
      assign driveCsN[i] = !(decodeHit && (cfg.csSel == 1'(i)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accPrev <= 1'b0;
      waitCnt <= '0;
    end else begin
      accPrev <= accAct;
      if (!accAct)
        waitCnt <= '0;
      else if (accStart)
        waitCnt <= (cfg.waitStates == '0) ? '0 : cfg.waitStates - 1'b1;
      else if (waitCnt != '0)
        waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitOn    = accAct && (accStart ? (cfg.waitStates != '0) : (waitCnt != '0));
  assign hostWaitN = !waitOn;

  assign stb.hit     = decodeHit;
  assign stb.rdDrive = decodeHit && hostRdStb && !cfg.rdProt;
  assign stb.wrDrive = decodeHit && hostWrStb;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cfg.winOff |-> (driveCsN == 2'b11 && hostWaitN && !stb.rdDrive)); // R3
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~driveCsN) <= 1); // R6
  AST_PROTECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cfg.rdProt |-> !stb.rdDrive); // R9
  AST_WAIT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (waitCnt != '0 && accAct) |=> (waitCnt == $past(waitCnt) - 1'b1)); // R10
  AST_WAIT_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.waitStates == '0 && $stable(cfg)) |-> hostWaitN); // R10
endmodule

// File: rtl/cwin_decoder.sv
module cwin_decoder
  import cwin_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regSel,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              hostCardSel,
  input  logic              hostMemSpace,
  input  logic              hostRdStb,
  input  logic              hostWrStb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [15:0]       hostDataIn,
  output logic [15:0]       hostDataOut,
  output logic              hostDataOe,
  output logic              hostWaitN,
  input  logic [15:0]       driveDataIn,
  output logic [15:0]       driveDataOut,
  output logic              driveDataOe,
  output logic [1:0]        driveCsN
);
  cfg_t    cfg;
  strobe_t stb;
  logic    addrMatch;

  cwin_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk(clk), .rstN(rstN),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .hostAddr(hostAddr), .hostDataIn(hostDataIn), .hostDataOut(hostDataOut),
    .hostDataOe(hostDataOe), .driveDataIn(driveDataIn), .driveDataOut(driveDataOut),
    .driveDataOe(driveDataOe), .stb(stb), .cfg(cfg), .addrMatch(addrMatch)
  );

  cwin_control u_control (
    .clk(clk), .rstN(rstN), .cfg(cfg), .addrMatch(addrMatch),
    .hostCardSel(hostCardSel), .hostMemSpace(hostMemSpace),
    .hostRdStb(hostRdStb), .hostWrStb(hostWrStb),
    .stb(stb), .hostWaitN(hostWaitN), .driveCsN(driveCsN)
  );
endmodule

// File: tb/cwin_decoder_bench.sv
`timescale 1ns/1ps
module cwin_decoder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regSel = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic hostCardSel = 1'b0, hostMemSpace = 1'b0, hostRdStb = 1'b0, hostWrStb = 1'b0;
  logic [9:0] hostAddr = '0;
  logic [15:0] hostDataIn = '0, hostDataOut, driveDataIn = '0, driveDataOut;
  logic hostDataOe, hostWaitN, driveDataOe;
  logic [1:0] driveCsN;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cwin_decoder u_cwin_decoder (.*);

  typedef struct packed {
    logic [7:0] ctrl;
    logic       mem;
    logic [9:0] addr;
    logic       rd;
    logic       wr;
    logic [1:0] expCs;
    logic       expOe;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'h12, 1'b1, 10'h1F3, 1'b1, 1'b0, 2'b10, 1'b1},  // R5 match, R4 memory
    '{8'h12, 1'b0, 10'h1F3, 1'b1, 1'b0, 2'b11, 1'b0},  // R4 wrong space
    '{8'h12, 1'b1, 10'h1E8, 1'b1, 1'b0, 2'b11, 1'b0},  // R5 mismatch
    '{8'h02, 1'b1, 10'h1E8, 1'b1, 1'b0, 2'b10, 1'b1},  // R5 compare off
    '{8'h00, 1'b0, 10'h000, 1'b1, 1'b0, 2'b10, 1'b1},  // R4 io space
    '{8'h20, 1'b0, 10'h000, 1'b1, 1'b0, 2'b01, 1'b1},  // R6 second select
    '{8'h28, 1'b0, 10'h000, 1'b1, 1'b0, 2'b01, 1'b0},  // R9 protect
    '{8'h01, 1'b0, 10'h000, 1'b1, 1'b0, 2'b11, 1'b0},  // R3 disabled
    '{8'h30, 1'b0, 10'h1F7, 1'b0, 1'b1, 2'b01, 1'b0},  // R5 write hit
    '{8'h30, 1'b0, 10'h1F8, 1'b0, 1'b1, 2'b11, 1'b0}   // R5 write miss
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic reg_write(input logic [7:0] ofs, input logic [7:0] data);
    @(negedge clk);
    regSel = ofs; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic idle_host();
    @(negedge clk);
    hostRdStb = 1'b0; hostWrStb = 1'b0; hostCardSel = 1'b0;
  endtask

  // starts an accepted access and checks wait over the next cycles
  task automatic wait_run(input logic [1:0] n, input logic wr);
    reg_write(8'h18, {n, 6'b000000});
    @(negedge clk);
    hostCardSel = 1'b1; hostMemSpace = 1'b0; hostRdStb = !wr; hostWrStb = wr;
    for (int c = 0; c < 5; c++) begin
      #1;
      check($sformatf("R10 n=%0d cycle=%0d", n, c), hostWaitN, (c < n) ? 0 : 1);
      @(negedge clk);
    end
    hostRdStb = 1'b0; hostWrStb = 1'b0; hostCardSel = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    regSel = 8'h18; #1;
    check("R1 ctrl reset", regRdData, 8'h01);
    regSel = 8'h20; #1;
    check("R1 base reset", regRdData, 8'h00);
    hostCardSel = 1'b1; hostRdStb = 1'b1; #1;
    check("R1 cs idle", driveCsN, 2'b11);
    check("R1 wait idle", hostWaitN, 1'b1);
    check("R1 oe idle", hostDataOe, 1'b0);
    idle_host();

    // R2 window registers, base 1F0 mask 3F8
    reg_write(8'h20, 8'hF0);
    reg_write(8'h21, 8'h01);
    reg_write(8'h22, 8'hF8);
    reg_write(8'h23, 8'h03);
    regSel = 8'h21; #1; check("R2 base hi", regRdData, 8'h01);
    regSel = 8'h22; #1; check("R2 mask lo", regRdData, 8'hF8);
    regSel = 8'h40; #1; check("R2 unmapped", regRdData, 8'h00);
    reg_write(8'h18, 8'h9E);
    regSel = 8'h18; #1; check("R2 ctrl readback", regRdData, 8'h9E);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      reg_write(8'h18, VECS[i].ctrl);
      @(negedge clk);
      hostCardSel = 1'b1; hostMemSpace = VECS[i].mem; hostAddr = VECS[i].addr;
      hostRdStb = VECS[i].rd; hostWrStb = VECS[i].wr;
      #1;
      check($sformatf("R6 vec%0d cs", i), driveCsN, VECS[i].expCs);
      check($sformatf("R9 vec%0d oe", i), hostDataOe, VECS[i].expOe);
      check($sformatf("R8 vec%0d drive oe", i), driveDataOe, VECS[i].wr && VECS[i].expCs != 2'b11);
      check($sformatf("R10 vec%0d no wait", i), hostWaitN, 1'b1);
      idle_host();
    end

    // R7 and R8 lane steering
    driveDataIn = 16'hA1B2; hostDataIn = 16'hC3D4;
    reg_write(8'h18, 8'h04);
    #1;
    check("R7 swap read", hostDataOut, 16'hB2A1);
    check("R8 swap write", driveDataOut, 16'hD4C3);
    reg_write(8'h18, 8'h00);
    #1;
    check("R7 straight read", hostDataOut, 16'hA1B2);
    check("R8 straight write", driveDataOut, 16'hC3D4);

    // R10 wait counts
    wait_run(2'd3, 1'b0);
    wait_run(2'd1, 1'b1);
    wait_run(2'd2, 1'b0);
    wait_run(2'd0, 1'b1);

    // R3 disabled window with wait programmed
    reg_write(8'h18, 8'hC1);
    @(negedge clk);
    hostCardSel = 1'b1; hostRdStb = 1'b1; #1;
    check("R3 no wait when off", hostWaitN, 1'b1);
    check("R3 no cs when off", driveCsN, 2'b11);
    check("R3 no oe when off", hostDataOe, 1'b0);
    idle_host();

    finish_run();
  end
endmodule